// File: doc/BRIEF.md
# Raster split sequencer

This block makes one video frame show two independent windows: a scrolling playfield on top and a fixed status panel below. It does this by reprogramming a character-row display controller at chosen moments in the frame. It drives the controller's register port, which takes two cycles per write: the first cycle selects a register number and the second cycle supplies the value. The controller is not part of this block.

A rising edge on the frame sync input starts a frame. The block writes the playfield start address and then counts 1 MHz ticks. When the first wait ends, it shortens the current display cycle to the playfield height, moves the sync row out of reach, sets the number of displayed rows and queues the panel start address. The controller therefore begins a second cycle at the panel. When the second wait ends, the block writes the totals the panel cycle needs. The two cycles together still fill the full 39-row frame and keep the sync in its usual place.

The wait lengths follow from rows × lines per row × ticks per line. All row counts derive from the playfield height and the frame height, so the frame always stays line-locked.

Top module: `raster_split_seq`

## Requirements
- R1: While reset is held and after it is released, no bus write occurs and `busy` stays low until a sync rising edge arrives, even if ticks keep coming.
- R2: A rising edge on `vsync` produces two register writes in this order: register 12 takes the high byte of the playfield address and register 13 takes the low byte. The first of these bus cycles appears on the clock after the edge is sampled.
- R3: Each register write takes two consecutive bus cycles. In the index cycle `bus_sel`=0 and `bus_data` carries the register number. In the data cycle `bus_sel`=1 and `bus_data` carries the value. There is one bus write per clock, and `busy` equals `bus_we` throughout.
- R4: After the sync writes finish, the first stage's writes start once exactly LEAD_ROWS × ROW_LINES × LINE_TICKS tick strobes (2560 by default) have been sampled after the last sync write.
- R5: The first stage writes, in order: register 4 (vertical total) = 15, register 7 (sync row) = 255, register 6 (displayed rows) = 16, register 12 = 0x06 and register 13 = 0x00.
- R6: After the first stage, a second wait of SPLIT_ROWS × ROW_LINES × LINE_TICKS strobes (8192 by default) passes before the second stage starts.
- R7: The second stage writes, in order: register 4 = 22, register 6 = 16 and register 7 = 18. No further write follows until the next sync edge.
- R8: The two vertical totals plus one each add up to 39 rows. The second sync row equals the second cycle's row count minus 5.
- R9: A sync edge always resets the stage selector to the first stage. Each timeout runs the stage that is due, and every write list begins only after a sync edge or a timeout.
- R10: A sync edge while a wait is running cancels that wait. The full sequence restarts, and no write from the old wait ever appears.
- R11: A sync edge while a write list is being emitted abandons that list and restarts from the sync writes.
- R12: The playfield address is captured on the sync edge. Changing it later in the frame affects only the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Frame sync level from the controller, synchronous to clk |
| tick | input | 1 | One-clock strobe at 1 MHz |
| pf_addr | input | 16 | Playfield start address, in controller word units |
| bus_we | output | 1 | Register bus write strobe |
| bus_sel | output | 1 | 0 = index cycle, 1 = data cycle |
| bus_data | output | 8 | Register number or register value |
| busy | output | 1 | High while a write list is being emitted |

## Verification
The bench builds the block with ROW_LINES = 2 and LINE_TICKS = 2. This shrinks the two waits to 20 and 64 tick strobes while keeping the default row counts, so every written value is the production value. With waits this short, a whole frame can be swept across tick spacings of one to three clocks and across many playfield addresses. The same setup also brings within reach a sync edge landing inside each wait, inside a write list, and a playfield address change after capture.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 16;

    localparam logic [BUS_W-1:0] REG_VTOTAL   = 8'd4;
    localparam logic [BUS_W-1:0] REG_VDISP    = 8'd6;
    localparam logic [BUS_W-1:0] REG_VSROW    = 8'd7;
    localparam logic [BUS_W-1:0] REG_START_HI = 8'd12;
    localparam logic [BUS_W-1:0] REG_START_LO = 8'd13;

    typedef enum logic [1:0] {
        LIST_SYNC    = 2'd0,
        LIST_CUT     = 2'd1,
        LIST_RESTORE = 2'd2
    } list_e;

    typedef enum logic {
        STAGE_CUT     = 1'b0,
        STAGE_RESTORE = 1'b1
    } stage_e;

    typedef struct packed {
        logic [BUS_W-1:0] idx;
        logic [BUS_W-1:0] val;
    } wr_s;

    typedef struct packed {
        logic [BUS_W-1:0]  vtot_cut;
        logic [BUS_W-1:0]  vsrow_cut;
        logic [BUS_W-1:0]  disp_rows;
        logic [BUS_W-1:0]  vtot_rest;
        logic [BUS_W-1:0]  vsrow_rest;
        logic [ADDR_W-1:0] panel;
    } regset_s;

    function automatic logic [2:0] list_len(list_e kind);
        case (kind)
            LIST_SYNC:    return 3'd2;
            LIST_CUT:     return 3'd5;
            default:      return 3'd3;
        endcase
    endfunction

    function automatic wr_s list_entry(list_e kind, logic [2:0] pos,
                                       logic [ADDR_W-1:0] pf, regset_s rs);
        wr_s w;
        w = '{idx: REG_START_HI, val: pf[15:8]};
        case (kind)
            LIST_SYNC: begin
                if (pos == 3'd1) w = '{idx: REG_START_LO, val: pf[7:0]};
            end
            LIST_CUT: begin
                case (pos)
                    3'd0:    w = '{idx: REG_VTOTAL,   val: rs.vtot_cut};
                    3'd1:    w = '{idx: REG_VSROW,    val: rs.vsrow_cut};
                    3'd2:    w = '{idx: REG_VDISP,    val: rs.disp_rows};
                    3'd3:    w = '{idx: REG_START_HI, val: rs.panel[15:8]};
                    default: w = '{idx: REG_START_LO, val: rs.panel[7:0]};
                endcase
            end
            default: begin
                case (pos)
                    3'd0:    w = '{idx: REG_VTOTAL, val: rs.vtot_rest};
                    3'd1:    w = '{idx: REG_VDISP,  val: rs.disp_rows};
                    default: w = '{idx: REG_VSROW,  val: rs.vsrow_rest};
                endcase
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rsplit_edge.sv
module rsplit_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/rsplit_timer.sv
module rsplit_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cancel,
    input  logic             tick,
    output logic             running,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign expire  = run_q && tick && (cnt_q == CNT_W'(1));
    assign running = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (cancel) begin
            run_q <= 1'b0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= load_val;
        end else if (run_q && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rsplit_emitter.sv
module rsplit_emitter
    import rsplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  list_e             start_kind,
    input  logic [ADDR_W-1:0] pf,
    input  regset_s           rs,
    output logic              bus_we,
    output logic              bus_sel,
    output logic [BUS_W-1:0]  bus_data,
    output logic              done,
    output list_e             done_kind
);
    list_e      kind_q;
    logic [2:0] pos_q;
    logic       data_q;
    logic       act_q;
    logic       last;
    wr_s        cur;

    assign cur  = list_entry(kind_q, pos_q, pf, rs);
    assign last = (pos_q == (list_len(kind_q) - 3'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            kind_q <= LIST_SYNC;
            pos_q  <= '0;
            data_q <= 1'b0;
        end else if (start) begin
            act_q  <= 1'b1;
            kind_q <= start_kind;
            pos_q  <= '0;
            data_q <= 1'b0;
        end else if (act_q) begin
            if (!data_q) begin
                data_q <= 1'b1;
            end else begin
                data_q <= 1'b0;
                if (last) act_q <= 1'b0;
                else      pos_q <= pos_q + 3'd1;
            end
        end
    end

    assign bus_we    = act_q;
    assign bus_sel   = data_q;
    assign bus_data  = act_q ? (data_q ? cur.val : cur.idx) : '0;
    assign done      = act_q && data_q && last;
    assign done_kind = kind_q;
endmodule

// File: rtl/raster_split_seq.sv
module raster_split_seq
    import rsplit_pkg::*;
#(
    parameter int                FRAME_ROWS    = 39,
    parameter int                SPLIT_ROWS    = 16,
    parameter int                LEAD_ROWS     = 5,
    parameter int                POST_VS_ROWS  = 5,
    parameter int                DISP_ROWS     = 16,
    parameter int                VS_OFF        = 255,
    parameter int                ROW_LINES     = 8,
    parameter int                LINE_TICKS    = 64,
    parameter logic [15:0]       PANEL_START   = 16'h0600
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        vsync,
    input  logic        tick,
    input  logic [15:0] pf_addr,
    output logic        bus_we,
    output logic        bus_sel,
    output logic [7:0]  bus_data,
    output logic        busy
);
    localparam int VT_CUT     = SPLIT_ROWS - 1;
    localparam int REST_ROWS  = FRAME_ROWS - SPLIT_ROWS;
    localparam int VT_REST    = REST_ROWS - 1;
    localparam int VS_REST    = REST_ROWS - POST_VS_ROWS;
    localparam int WAIT_LEAD  = LEAD_ROWS * ROW_LINES * LINE_TICKS;
    localparam int WAIT_SPLIT = SPLIT_ROWS * ROW_LINES * LINE_TICKS;
    localparam int WAIT_MAX   = (WAIT_LEAD > WAIT_SPLIT) ? WAIT_LEAD : WAIT_SPLIT;
    localparam int CNT_W      = $clog2(WAIT_MAX + 1);

    regset_s           rs;
    logic              vs_rise;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_cancel;
    logic              tmr_run;
    logic              tmr_expire;
    logic              em_start;
    list_e             em_kind;
    logic              em_done;
    list_e             em_done_kind;
    stage_e            stage_q;
    logic [ADDR_W-1:0] pf_hold;

    assign rs = '{vtot_cut:   BUS_W'(VT_CUT),
                  vsrow_cut:  BUS_W'(VS_OFF),
                  disp_rows:  BUS_W'(DISP_ROWS),
                  vtot_rest:  BUS_W'(VT_REST),
                  vsrow_rest: BUS_W'(VS_REST),
                  panel:      PANEL_START};

    rsplit_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (vsync),
        .rise  (vs_rise)
    );

    rsplit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cancel   (tmr_cancel),
        .tick     (tick),
        .running  (tmr_run),
        .expire   (tmr_expire)
    );

    rsplit_emitter u_emit (
        .clk       (clk),
        .rst       (rst),
        .start     (em_start),
        .start_kind(em_kind),
        .pf        (pf_hold),
        .rs        (rs),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_data  (bus_data),
        .done      (em_done),
        .done_kind (em_done_kind)
    );

    always_comb begin
        em_start   = 1'b0;
        em_kind    = LIST_SYNC;
        tmr_load   = 1'b0;
        tmr_val    = CNT_W'(WAIT_LEAD);
        tmr_cancel = 1'b0;
        if (vs_rise) begin
            em_start   = 1'b1;
            tmr_cancel = 1'b1;
        end else if (tmr_expire) begin
            em_start = 1'b1;
            em_kind  = (stage_q == STAGE_CUT) ? LIST_CUT : LIST_RESTORE;
        end else if (em_done) begin
            case (em_done_kind)
                LIST_SYNC: begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WAIT_LEAD);
                end
                LIST_CUT: begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WAIT_SPLIT);
                end
                default: tmr_load = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= STAGE_CUT;
            pf_hold <= '0;
        end else if (vs_rise) begin
            stage_q <= STAGE_CUT;
            pf_hold <= pf_addr;
        end else if (tmr_expire && stage_q == STAGE_CUT) begin
            stage_q <= STAGE_RESTORE;
        end
    end

    assign busy = bus_we;
endmodule

// File: rtl/rsplit_checker.sv
module rsplit_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic        bus_sel,
    input logic [7:0]  bus_data,
    input logic        busy,
    input logic        rise,
    input logic        expire,
    input logic        tmr_run,
    input logic [15:0] pf_hold,
    input logic [15:0] pf_addr
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!bus_we && !busy));

    assert_sync_write_first_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> (bus_we && !bus_sel && bus_data == 8'd12));

    assert_data_after_index_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_sel) |-> ($past(bus_we) && !$past(bus_sel)));

    assert_no_wait_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !tmr_run);

    assert_write_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !$past(bus_we)) |-> ($past(rise) || $past(expire)));

    assert_wait_cancelled_R10: assert property (@(posedge clk) disable iff (rst)
        rise |=> !tmr_run);

    assert_addr_captured_R12: assert property (@(posedge clk) disable iff (rst)
        rise |=> (pf_hold == $past(pf_addr)));

    assert_addr_held_R12: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(pf_hold));
endmodule

bind raster_split_seq rsplit_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_sel  (bus_sel),
    .bus_data (bus_data),
    .busy     (busy),
    .rise     (vs_rise),
    .expire   (tmr_expire),
    .tmr_run  (tmr_run),
    .pf_hold  (pf_hold),
    .pf_addr  (pf_addr)
);

// File: tb/raster_split_seq_test.sv
`timescale 1ns/1ps
module raster_split_seq_test;
    localparam int RL = 2;
    localparam int LT = 2;
    localparam int W1 = 5 * RL * LT;
    localparam int W2 = 16 * RL * LT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vsync = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] pf_addr = 16'h0000;
    wire         bus_we, bus_sel, busy;
    wire  [7:0]  bus_data;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tick_ctr = 0;
    int tick_edges = 0;

    raster_split_seq #(.ROW_LINES(RL), .LINE_TICKS(LT)) uut (
        .clk(clk), .rst(rst), .vsync(vsync), .tick(tick), .pf_addr(pf_addr),
        .bus_we(bus_we), .bus_sel(bus_sel), .bus_data(bus_data), .busy(busy)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (tick_ctr + 1 >= tick_div) begin
            tick_ctr <= 0;
            tick     <= 1'b1;
        end else begin
            tick_ctr <= tick_ctr + 1;
            tick     <= 1'b0;
        end
        if (tick) tick_edges <= tick_edges + 1;
    end

    // bus monitor: pairs index/data cycles, measures tick gaps between lists
    int   log_n = 0;
    int   log_idx [0:31];
    int   log_val [0:31];
    int   gap_n = 0;
    int   gap_v [0:7];
    int   proto_err = 0;
    int   snap = 0;
    logic snap_ok = 1'b0;
    logic pend = 1'b0;
    int   pend_idx = 0;
    logic prev_we = 1'b0;
    logic mon_vs_prev = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            log_n = 0; gap_n = 0; pend = 1'b0; snap_ok = 1'b0;
            prev_we = 1'b0; mon_vs_prev = 1'b0;
        end else begin
            if (bus_we !== busy) proto_err++;
            if (bus_we) begin
                if (!prev_we && snap_ok) begin
                    if (gap_n < 8) gap_v[gap_n] = tick_edges - snap;
                    gap_n++;
                    snap_ok = 1'b0;
                end
                if (!bus_sel) begin
                    pend = 1'b1;
                    pend_idx = int'(bus_data);
                end else if (!pend) begin
                    proto_err++;
                end else begin
                    if (log_n < 32) begin
                        log_idx[log_n] = pend_idx;
                        log_val[log_n] = int'(bus_data);
                    end
                    log_n++;
                    pend = 1'b0;
                end
            end else if (prev_we) begin
                snap = tick_edges;
                snap_ok = 1'b1;
            end
            prev_we = bus_we;
            if (vsync && !mon_vs_prev) begin
                log_n = 0; gap_n = 0; pend = 1'b0; snap_ok = 1'b0;
            end
            mon_vs_prev = vsync;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_idx(int i);
        case (i)
            0: return 12;  1: return 13;  2: return 4;  3: return 7;  4: return 6;
            5: return 12;  6: return 13;  7: return 4;  8: return 6;  default: return 7;
        endcase
    endfunction

    function automatic int exp_val(int i, logic [15:0] pf);
        case (i)
            0: return int'(pf[15:8]);
            1: return int'(pf[7:0]);
            2: return 15;  3: return 255;  4: return 16;
            5: return 6;   6: return 0;
            7: return 22;  8: return 16;   default: return 18;
        endcase
    endfunction

    task automatic drive_sync(input logic [15:0] pf);
        @(posedge clk); #1;
        pf_addr = pf;
        vsync = 1'b1;
        @(posedge clk); #1;
        pf_addr = ~pf;
        repeat (3) @(posedge clk);
        #1 vsync = 1'b0;
    endtask

    task automatic settle();
        repeat ((W1 + W2) * tick_div + 80) @(posedge clk);
    endtask

    task automatic verify_frame(input logic [15:0] pf, input string tag);
        check(tag, "write count", log_n, 10);
        for (int i = 0; i < 10; i++) begin
            string req;
            req = (i < 2) ? "R2" : ((i < 7) ? "R5" : "R7");
            check(req, $sformatf("%s index of write %0d", tag, i), log_idx[i], exp_idx(i));
            check(req, $sformatf("%s value of write %0d", tag, i), log_val[i], exp_val(i, pf));
        end
        check("R12", $sformatf("%s captured address high", tag), log_val[0], int'(pf[15:8]));
        check("R4", $sformatf("%s first wait ticks", tag), gap_v[0], W1);
        check("R6", $sformatf("%s second wait ticks", tag), gap_v[1], W2);
        check("R9", $sformatf("%s list count", tag), gap_n, 2);
        check("R8", $sformatf("%s total rows", tag), (log_val[2] + 1) + (log_val[7] + 1), 39);
        check("R8", $sformatf("%s sync row", tag), log_val[9], log_val[7] + 1 - 5);
        check("R3", $sformatf("%s protocol errors", tag), proto_err, 0);
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check("R1", "bus_we in reset", int'(bus_we), 0);
        check("R1", "busy in reset", int'(busy), 0);
        rst = 1'b0;
        repeat (60) @(posedge clk);
        #1;
        check("R1", "writes without sync", log_n, 0);
        check("R1", "busy without sync", int'(busy), 0);

        // sweep: tick spacing x playfield address
        for (int d = 1; d <= 3; d++) begin
            for (int h = 0; h < 4; h++) begin
                logic [15:0] pf;
                pf = {8'(h * 37 + 11 + d), 8'(h * 91 + 3 * d)};
                tick_div = d;
                drive_sync(pf);
                settle();
                verify_frame(pf, "sweep");
            end
        end

        // no re-run without a new sync edge (R9 / R7)
        repeat (W2 * 3 * 2) @(posedge clk);
        check("R7", "writes after second stage", log_n, 10);

        // sync edge during the first wait
        tick_div = 2;
        drive_sync(16'h1234);
        while (log_n < 2) @(negedge clk);
        repeat (W1) @(posedge clk);
        drive_sync(16'hA5C3);
        settle();
        verify_frame(16'hA5C3, "R10");

        // sync edge during the second wait
        drive_sync(16'h0F0F);
        while (log_n < 7) @(negedge clk);
        repeat (W2) @(posedge clk);
        drive_sync(16'h7E81);
        settle();
        verify_frame(16'h7E81, "R10");

        // sync edge while the first-stage list is on the bus
        drive_sync(16'h2468);
        while (!(log_n >= 3 && bus_we)) @(negedge clk);
        drive_sync(16'h9BDF);
        settle();
        verify_frame(16'h9BDF, "R11");

        // sync edge while the second-stage list is on the bus
        tick_div = 1;
        drive_sync(16'h5555);
        while (!(log_n >= 8 && bus_we)) @(negedge clk);
        drive_sync(16'hC001);
        settle();
        verify_frame(16'hC001, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule